// File: doc/BRIEF.md
# Battery protection register slave on a two-wire serial bus

This block lets a host controller reach a small bank of protection registers over a standard I2C bus. The block is only ever a target: it watches SCL and SDA through synchronizers, recognises START and STOP, matches its own 7-bit device address, and then takes a pointer byte followed by data bytes, or returns data. The pointer is kept from one transaction to the next and never advances. A later read can therefore fetch the register that the last write pointed at without naming it again. Several bytes in one transfer all address the same register.

Register 0 holds sticky status bits. Each bit sets when its condition input is high. An open-drain, active-low alert is pulled whenever a new status bit latches. Reading the status register clears the bits whose conditions have gone and releases the alert, unless a condition is still present. Registers 1 to `NUM_CFG` are configuration bytes, and they drive the `cfg_o` bus. A sleep input keeps writes working but hides all read data.

Top module: `bpc_i2c_regs`

## Requirements
- R1: Only the parameter address `DEV_ADDR` (7 bits, followed by an R/W bit where 0 = write, 1 = read) is acknowledged. Any other address, including the general call address 0x00, gets no ACK, and SDA stays released until the next START.
- R2: The block never drives SCL. It changes its SDA pull-down only while SCL is low.
- R3: In a write transaction, the first byte after the address is the register pointer, and it is acknowledged. Every following byte is written to that same register, with no auto-increment, so the last byte is the value in effect. Configuration changes only through such a write.
- R4: A read transaction uses the pointer left by the most recent write transaction. Every byte of a read returns the same register. Bytes continue while the master ACKs and end after a NACK. Data goes out MSB first.
- R5: Map: address 0x00 is read-only status, with the bits in the low `STAT_W` positions and the upper bits reading 0. Address k, for k from 1 to `NUM_CFG`, is a configuration byte that appears on `cfg_o[8k-1:8k-8]`.
- R6: A write to an unimplemented address, or to the status register, is acknowledged and discarded. A read of an unimplemented address returns 0x00.
- R7: While `sleep_i` is high, writes are acknowledged and take effect, and every read returns 0x00 without clearing status.
- R8: A status bit latches while its `cond_i` bit is high. `alert_low_o` goes high (pull the line low) on the clock after any bit newly latches, and it stays high while any condition is present.
- R9: A status read outside sleep clears the latched bits whose conditions are no longer present. It drops `alert_low_o` unless some condition is still high.
- R10: After reset, every configuration byte and status bit is 0, `alert_low_o` is 0, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| sleep_i | input | 1 | Low-power mode: reads return 0x00 |
| cond_i | input | STAT_W | Live fault conditions feeding the status bits |
| cfg_o | output | NUM_CFG*8 | Configuration bytes, register k in byte k-1 |
| alert_low_o | output | 1 | 1 pulls the alert line low |

## Verification
A corrupted pointer shows up within one transaction: the read-back byte comes from the wrong register, or a write lands in a neighbouring byte of `cfg_o`. A protocol state machine that is out of step shows up at the very next acknowledge bit, either as a missing ACK or as an ACK to a foreign or general call address. A wrong status latch or clear shows up on `alert_low_o` one clock after the condition changes, or in the byte returned by the next status read. Sleep gating errors appear as a non-zero read byte, or as an alert that drops while sleep is still high.

// File: rtl/bpc_i2c_pkg.sv
package bpc_i2c_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
        S_WDAT, S_WDAT_ACK, S_RDAT, S_RDAT_ACK
    } xfer_state_e;

    typedef enum logic [1:0] {
        K_STATUS, K_CONFIG, K_NONE
    } reg_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    localparam logic [7:0] STATUS_ADDR = 8'h00;

    function automatic reg_kind_e kind_of(input logic [7:0] addr, input int unsigned n_cfg);
        if (addr == STATUS_ADDR)
            return K_STATUS;
        if ({24'd0, addr} <= n_cfg)
            return K_CONFIG;
        return K_NONE;
    endfunction

endpackage

// File: rtl/bpc_i2c_sync.sv
module bpc_i2c_sync
    import bpc_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.sda      = sda_s;
    end
endmodule

// File: rtl/bpc_i2c_engine.sv
module bpc_i2c_engine
    import bpc_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output wr_req_t    wr,
    output logic       rd_stb,
    output logic [7:0] ptr
);
    xfer_state_e st;
    logic [3:0]  cnt;
    logic [7:0]  sh, tx;
    logic        rw, mack;

    assign rd_stb = evt.scl_fall &&
                    ((st == S_ADDR_ACK && rw) || (st == S_RDAT_ACK && !mack));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            mack   <= 1'b1;
            sda_oe <= 1'b0;
            ptr    <= STATUS_ADDR;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                st     <= S_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_PTR, S_WDAT: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[6:0], evt.sda};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == S_ADDR) begin
                                if (sh[7:1] == DEV_ADDR && sh[7:1] != 7'd0) begin
                                    rw     <= sh[0];
                                    sda_oe <= 1'b1;
                                    st     <= S_ADDR_ACK;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end else if (st == S_PTR) begin
                                ptr    <= sh;
                                sda_oe <= 1'b1;
                                st     <= S_PTR_ACK;
                            end else begin
                                wr.en   <= 1'b1;
                                wr.addr <= ptr;
                                wr.data <= sh;
                                sda_oe  <= 1'b1;
                                st      <= S_WDAT_ACK;
                            end
                        end
                    end
                    S_ADDR_ACK: if (evt.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            st     <= S_RDAT;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= S_PTR;
                        end
                    end
                    S_PTR_ACK, S_WDAT_ACK: if (evt.scl_fall) begin
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        st     <= S_WDAT;
                    end
                    S_RDAT: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= S_RDAT_ACK;
                            end else if (cnt != 4'd0) begin
                                sda_oe <= ~tx[3'd7 - cnt[2:0]];
                            end
                        end
                    end
                    S_RDAT_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            cnt <= '0;
                            if (!mack) begin
                                tx     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                st     <= S_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= S_IDLE;
                            end
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/bpc_reg_bank.sv
module bpc_reg_bank
    import bpc_i2c_pkg::*;
#(
    parameter int NUM_CFG = 3,
    parameter int STAT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              wr,
    input  logic                 rd_stb,
    input  logic [7:0]           rd_addr,
    input  logic                 sleep,
    input  logic [STAT_W-1:0]    cond,
    output logic [7:0]           rd_byte,
    output logic [NUM_CFG*8-1:0] cfg,
    output logic                 alert
);
    logic [NUM_CFG-1:0][7:0] cfg_q;
    logic [STAT_W-1:0]       stat_q;
    logic                    rd_clr;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[g] <= 8'h00;
            else if (wr.en && wr.addr == 8'(g + 1))
                cfg_q[g] <= wr.data;
        end
        assign cfg[g*8 +: 8] = cfg_q[g];
    end

    always_comb begin
        rd_byte = 8'h00;
        if (!sleep) begin
            case (kind_of(rd_addr, NUM_CFG))
                K_STATUS: rd_byte[STAT_W-1:0] = stat_q;
                K_CONFIG: begin
                    for (int k = 0; k < NUM_CFG; k++)
                        if (rd_addr == 8'(k + 1))
                            rd_byte = cfg_q[k];
                end
                default: rd_byte = 8'h00;
            endcase
        end
    end

    assign rd_clr = rd_stb && !sleep && kind_of(rd_addr, NUM_CFG) == K_STATUS;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            alert  <= 1'b0;
        end else if (rd_clr) begin
            stat_q <= cond;
            alert  <= |cond;
        end else begin
            stat_q <= stat_q | cond;
            if ((stat_q | cond) != stat_q)
                alert <= 1'b1;
        end
    end
endmodule

// File: rtl/bpc_i2c_regs.sv
module bpc_i2c_regs
    import bpc_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_CFG  = 3,
    parameter int         STAT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic                 sleep_i,
    input  logic [STAT_W-1:0]    cond_i,
    output logic [NUM_CFG*8-1:0] cfg_o,
    output logic                 alert_low_o
);
    bus_evt_t   evt;
    wr_req_t    wr_bus;
    logic       rd_stb_w;
    logic [7:0] rd_byte_w;
    logic [7:0] ptr_w;
    logic       wr_en_w;

    assign wr_en_w = wr_bus.en;

    bpc_i2c_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    bpc_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_byte (rd_byte_w),
        .sda_oe  (sda_oe_o),
        .wr      (wr_bus),
        .rd_stb  (rd_stb_w),
        .ptr     (ptr_w)
    );

    bpc_reg_bank #(.NUM_CFG(NUM_CFG), .STAT_W(STAT_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_bus),
        .rd_stb  (rd_stb_w),
        .rd_addr (ptr_w),
        .sleep   (sleep_i),
        .cond    (cond_i),
        .rd_byte (rd_byte_w),
        .cfg     (cfg_o),
        .alert   (alert_low_o)
    );
endmodule

// File: rtl/bpc_i2c_regs_chk.sv
module bpc_i2c_regs_chk #(
    parameter int CFG_BITS = 24,
    parameter int STAT_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                scl_i,
    input logic                sda_oe,
    input logic                sleep_i,
    input logic [STAT_W-1:0]   cond_i,
    input logic [CFG_BITS-1:0] cfg_o,
    input logic                alert,
    input logic                wr_en,
    input logic                rd_stb,
    input logic [7:0]          rd_byte
);
    // R2: the data pull-down only moves while the bus clock is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);

    // R3: configuration bytes change only after a write strobe from the engine
    a_r3_cfg_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_o));

    // R7: a fetch during sleep hands the engine a zero byte
    a_r7_sleep_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sleep_i && rd_stb) |-> (rd_byte == 8'h00));

    // R8: a present condition always leaves the alert pulled
    a_r8_alert_on_cond: assert property (@(posedge clk) disable iff (rst)
        (cond_i != '0) |=> alert);
endmodule

bind bpc_i2c_regs bpc_i2c_regs_chk #(.CFG_BITS(NUM_CFG*8), .STAT_W(STAT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe_o),
    .sleep_i (sleep_i),
    .cond_i  (cond_i),
    .cfg_o   (cfg_o),
    .alert   (alert_low_o),
    .wr_en   (wr_en_w),
    .rd_stb  (rd_stb_w),
    .rd_byte (rd_byte_w)
);

// File: tb/test_bpc_i2c_regs.sv
module test_bpc_i2c_regs;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam logic [6:0] DEV        = 7'h2A;
    localparam int         NCFG       = 3;
    localparam int         SW         = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic sleep = 1'b0;
    logic [SW-1:0] cond = '0;
    logic sda_oe;
    logic sda_line;
    logic [NCFG*8-1:0] cfg;
    logic alert;

    int n_cmp = 0;
    int n_bad = 0;
    int oe_cnt = 0;
    logic [7:0] cfg_m [1:NCFG];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = ~(m_low | sda_oe);
    always @(posedge clk) if (sda_oe) oe_cnt++;

    bpc_i2c_regs #(.DEV_ADDR(DEV), .NUM_CFG(NCFG), .STAT_W(SW)) i_bpc_i2c_regs (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .sleep_i(sleep), .cond_i(cond), .cfg_o(cfg), .alert_low_o(alert)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCFG*8-1:0] cfg_model();
        logic [NCFG*8-1:0] v;
        for (int k = 1; k <= NCFG; k++) v[(k-1)*8 +: 8] = cfg_m[k];
        return v;
    endfunction

    task automatic b_start();
        m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic b_stop();
        m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        m_low = 1'b0; tick(2*Q);
    endtask

    task automatic b_wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
        end
        m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic b_rbyte(input logic mack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl_m = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl_m = 1'b0; tick(Q);
        end
        m_low = mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q); m_low = 1'b0;
    endtask

    task automatic wr_txn(input string req, input logic [7:0] ptr, input int nb,
                          input logic [7:0] d0, input logic [7:0] d1);
        logic ack;
        b_start();
        b_wbyte({DEV, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
        b_wbyte(ptr, ack);         chk({req, " ptr ack"}, ack, 1);
        if (nb > 0) begin b_wbyte(d0, ack); chk({req, " data0 ack"}, ack, 1); end
        if (nb > 1) begin b_wbyte(d1, ack); chk({req, " data1 ack"}, ack, 1); end
        b_stop();
        if (nb > 0 && ptr >= 1 && ptr <= NCFG) cfg_m[ptr] = (nb > 1) ? d1 : d0;
    endtask

    task automatic rd_txn(input string req, input int nb, output logic [7:0] b0, output logic [7:0] b1);
        logic ack;
        b1 = 8'h00;
        b_start();
        b_wbyte({DEV, 1'b1}, ack); chk({req, " read addr ack"}, ack, 1);
        b_rbyte(nb > 1 ? 1'b1 : 1'b0, b0);
        if (nb > 1) b_rbyte(1'b0, b1);
        b_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r0, r1, d0, d1;
        logic ack;
        int snap;
        for (int k = 1; k <= NCFG; k++) cfg_m[k] = 8'h00;
        tick(5); rst = 1'b0; tick(3);

        // R10 reset state
        chk("R10 cfg", cfg, 0);
        chk("R10 alert", alert, 0);
        chk("R10 sda", sda_oe, 0);

        // R3 R5 R6: sweep every implemented and one unimplemented address
        for (int a = 0; a <= NCFG + 1; a++) begin
            d0 = 8'(a * 37 + 5);
            d1 = 8'(a * 53 + 17);
            wr_txn("R3", 8'(a), 2, d0, d1);
            chk("R3 R5 cfg after write", cfg, cfg_model());
            rd_txn("R4", 2, r0, r1);
            chk("R4 R5 R6 read byte0", r0, (a >= 1 && a <= NCFG) ? d1 : 8'h00);
            chk("R4 R5 R6 read byte1", r1, (a >= 1 && a <= NCFG) ? d1 : 8'h00);
        end

        // R1 foreign and general call addresses, both directions
        for (int j = 0; j < 3; j++) begin
            logic [6:0] fa;
            fa = (j == 0) ? (DEV ^ 7'h01) : (j == 1) ? 7'h00 : (DEV ^ 7'h40);
            for (int rwb = 0; rwb < 2; rwb++) begin
                snap = oe_cnt;
                b_start();
                b_wbyte({fa, rwb[0]}, ack); chk("R1 no ack foreign addr", ack, 0);
                b_wbyte(8'h01, ack);        chk("R1 no ack after foreign addr", ack, 0);
                b_wbyte(8'hFF, ack);
                b_stop();
                chk("R1 sda never pulled", oe_cnt - snap, 0);
                chk("R1 cfg untouched", cfg, cfg_model());
            end
        end

        // R4 pointer retained across transactions
        wr_txn("R4 set ptr", 8'd2, 0, 8'h00, 8'h00);
        rd_txn("R4", 2, r0, r1);
        chk("R4 retained ptr byte0", r0, cfg_m[2]);
        chk("R4 retained ptr byte1", r1, cfg_m[2]);

        // R8 R9: pulse conditions, read and clear
        cond = 4'b0101; tick(2); cond = 4'b0000; tick(2);
        chk("R8 alert after pulse", alert, 1);
        wr_txn("R9 ptr0", 8'd0, 0, 8'h00, 8'h00);
        rd_txn("R9", 1, r0, r1);
        chk("R8 latched status", r0, 8'h05);
        chk("R9 alert released", alert, 0);

        // R9 held condition keeps alert
        cond = 4'b0010; tick(3);
        rd_txn("R9", 1, r0, r1);
        chk("R9 held status", r0, 8'h02);
        chk("R9 alert held", alert, 1);
        cond = 4'b0000; tick(3);
        rd_txn("R9", 1, r0, r1);
        chk("R8 bit still latched", r0, 8'h02);
        chk("R9 alert cleared", alert, 0);
        rd_txn("R9", 1, r0, r1);
        chk("R9 status cleared", r0, 8'h00);

        // R7 sleep: writes work, reads zero, status kept
        sleep = 1'b1;
        wr_txn("R7", 8'd1, 2, 8'hA5, 8'hC3);
        chk("R7 write in sleep", cfg, cfg_model());
        rd_txn("R7", 2, r0, r1);
        chk("R7 read zero", r0, 8'h00);
        chk("R7 read zero byte1", r1, 8'h00);
        cond = 4'b1000; tick(2); cond = 4'b0000; tick(2);
        wr_txn("R7 ptr0", 8'd0, 0, 8'h00, 8'h00);
        rd_txn("R7", 1, r0, r1);
        chk("R7 status hidden", r0, 8'h00);
        chk("R7 alert kept", alert, 1);
        sleep = 1'b0; tick(2);
        rd_txn("R9", 1, r0, r1);
        chk("R7 status after wake", r0, 8'h08);
        chk("R9 alert after wake read", alert, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule